// File: doc/BRIEF.md
# Flash protection guard

This block sits between a flash array and the fetch/load path of a processor and enforces two kinds of protection from one 16-bit protection word. The low bits each guard one erase block against program and erase; a separate high bit turns on code protection, under which any read of the array by code that is not itself executing from the flash receives a fixed trap opcode (0x009B) in place of the stored data.

The protection word is held twice. A pending copy models the non-volatile cells: it powers up as all ones, it can only have bits cleared, and it is written by a set-protection strobe. An active copy drives all the gating and the status read. It is loaded from the pending copy at every system reset, so a new setting takes effect only after the next reset. Two temporary-unprotect flags soften the active word until the next reset. One lifts protection for every block at once. The other lifts code protection, and it can be set or cleared only by magic-word writes issued from in-flash code.

A power-on reset initialises the pending copy. A system reset reloads the active copy and clears both temporary flags.

Top module: `flash_prot_guard`

## Requirements
- R1: After power-on reset the pending and active words are 0xFFFF, every block permit is 1, a status read returns 0xFFFF and no read is trapped.
- R2: When active bit b (b = 0..10) is 0 and block temporary unprotect is not in effect, `blk_permit[b]` is 0; otherwise it is 1.
- R3: A set-protection strobe whose value only clears bits is accepted. The pending word becomes the written value with unimplemented bits 11..14 forced to 1.
- R4: A set-protection strobe that would turn any implemented pending bit (0..10 or 15) from 0 to 1 is rejected. The pending word is unchanged, and `set_err` is 1 during the single cycle after the strobe.
- R5: An accepted value does not change the permits, the trap or the status read until a system reset. At that reset the active word is loaded from the pending word.
- R6: While active bit 15 is 0 and code temporary unprotect is not set, an array read with `in_flash_exec` = 0 returns 0x009B. A read with `in_flash_exec` = 1 returns `arr_rdata`.
- R7: A `blk_unlock` strobe makes every block permit 1 until the next system reset.
- R8: A write of 0xFFFF with `in_flash_exec` = 1 sets code temporary unprotect. A write of 0xFFFB with `in_flash_exec` = 1 clears it. Either write with `in_flash_exec` = 0 is ignored.
- R9: With `stat_rd` = 1 and byte-address bits [1:0] = 2'b10 (addresses 4n-2), `rd_data` is the active word, whatever the code protection. Other addresses take the normal array path.
- R10: A system reset clears both temporary-unprotect flags and does not change the pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low; initialises the pending word |
| rst_n | input | 1 | Synchronous system reset, active low; reloads the active word, clears temporary flags |
| set_stb | input | 1 | Set-protection command strobe |
| set_val | input | 16 | Protection value carried by `set_stb` |
| blk_unlock | input | 1 | Block temporary unprotect command strobe |
| wr_stb | input | 1 | Array write strobe (checked for the code unlock/relock words) |
| wr_data | input | 16 | Array write data |
| in_flash_exec | input | 1 | 1 when the current access comes from code running in the flash |
| stat_rd | input | 1 | Protection status read mode |
| rd_addr_lsb | input | 2 | Byte-address bits [1:0] of the read |
| arr_rdata | input | 16 | Data read from the flash array |
| rd_data | output | 16 | Read data after status selection and trap substitution |
| blk_permit | output | 11 | Per-block program/erase permit |
| set_err | output | 1 | One-cycle pulse for a rejected set-protection strobe |

## Verification
The assertions assume that power-on reset is applied before the first use and that `set_stb`, `blk_unlock` and `wr_stb` are single-cycle strobes sampled only outside reset. The one-way property of the pending word and the stability of the active word outside system reset rely on this. The stimulus drives every input on the falling clock edge and holds each strobe for exactly one cycle. It applies both resets only as whole-cycle pulses, so every property sees clean reset boundaries. Read-path inputs are changed only between clock edges, and a behavioural model is compared on every cycle as well.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

   localparam int PROT_W = 16;

   typedef logic [PROT_W-1:0] prot_word_t;

   // byte-address low bits that select the protection status word
   localparam logic [1:0] STAT_LSB = 2'b10;

   // bits of the protection word that exist: block bits plus the code bit
   function automatic prot_word_t impl_mask(input int nblk, input int cbit);
      prot_word_t m;
      m = '0;
      for (int i = 0; i < PROT_W; i++) begin
         if (i < nblk || i == cbit) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/fpg_prot_regs.sv
module fpg_prot_regs
   import fpg_pkg::*;
#(
   parameter prot_word_t IMPL = 16'h87FF
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_n,
   input  logic       set_stb,
   input  prot_word_t set_val,
   output prot_word_t pend_q,
   output prot_word_t act_q,
   output logic       set_err_q
);

   prot_word_t raise_bits;
   logic       raise_any;

   assign raise_bits = ~pend_q & set_val & IMPL;
   assign raise_any  = |raise_bits;

   always_ff @(posedge clk) begin
      if (!por_n) begin
         pend_q    <= '1;
         act_q     <= '1;
         set_err_q <= 1'b0;
      end else if (!rst_n) begin
         act_q     <= pend_q;
         set_err_q <= 1'b0;
      end else begin
         set_err_q <= 1'b0;
         if (set_stb) begin
            if (raise_any) set_err_q <= 1'b1;
            else           pend_q    <= set_val | ~IMPL;
         end
      end
   end

   AST_PEND_ONEWAY: assert property (@(posedge clk) disable iff (!por_n)
      set_stb |=> ((pend_q & ~$past(pend_q)) == '0)); // R3

   AST_ERR_KEEPS_PEND: assert property (@(posedge clk) disable iff (!por_n)
      set_err_q |-> $stable(pend_q)); // R4

   AST_ACT_ONLY_AT_RESET: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $past(rst_n && por_n) |-> $stable(act_q)); // R5

endmodule

// File: rtl/fpg_unlock_ctl.sv
module fpg_unlock_ctl
   import fpg_pkg::*;
#(
   parameter prot_word_t UNLOCK_WORD = 16'hFFFF,
   parameter prot_word_t RELOCK_WORD = 16'hFFFB
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_n,
   input  logic       blk_cmd,
   input  logic       wr_stb,
   input  prot_word_t wr_data,
   input  logic       in_flash,
   output logic       blk_tmp_q,
   output logic       code_tmp_q
);

   if (UNLOCK_WORD == RELOCK_WORD) begin : g_bad_words
      $error("fpg_unlock_ctl: unlock and relock words must differ");
   end

   logic code_wr;

   assign code_wr = wr_stb && in_flash;

   always_ff @(posedge clk) begin
      if (!por_n || !rst_n) begin
         blk_tmp_q  <= 1'b0;
         code_tmp_q <= 1'b0;
      end else begin
         if (blk_cmd) blk_tmp_q <= 1'b1;
         if (code_wr && wr_data == UNLOCK_WORD)      code_tmp_q <= 1'b1;
         else if (code_wr && wr_data == RELOCK_WORD) code_tmp_q <= 1'b0;
      end
   end

   AST_BLK_TMP_STICKY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      blk_tmp_q |=> blk_tmp_q); // R7

   AST_CODE_TMP_SOURCE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $rose(code_tmp_q) |-> $past(wr_stb && in_flash)); // R8

endmodule

// File: rtl/fpg_read_sel.sv
module fpg_read_sel
   import fpg_pkg::*;
#(
   parameter prot_word_t TRAP_WORD = 16'h009B
) (
   input  logic       stat_rd,
   input  logic [1:0] addr_lsb,
   input  logic       in_flash,
   input  logic       code_lock,
   input  prot_word_t act_word,
   input  prot_word_t arr_rdata,
   output prot_word_t rd_data
);

   logic stat_hit;
   logic trap_hit;

   assign stat_hit = stat_rd && (addr_lsb == STAT_LSB);
   assign trap_hit = code_lock && !in_flash;

   always_comb begin
      if (stat_hit)      rd_data = act_word;
      else if (trap_hit) rd_data = TRAP_WORD;
      else               rd_data = arr_rdata;
   end

endmodule

// File: rtl/flash_prot_guard.sv
module flash_prot_guard
   import fpg_pkg::*;
#(
   parameter int         NUM_BLK     = 11,
   parameter int         CODE_BIT    = 15,
   parameter prot_word_t TRAP_WORD   = 16'h009B,
   parameter prot_word_t UNLOCK_WORD = 16'hFFFF,
   parameter prot_word_t RELOCK_WORD = 16'hFFFB
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               rst_n,
   input  logic               set_stb,
   input  logic [15:0]        set_val,
   input  logic               blk_unlock,
   input  logic               wr_stb,
   input  logic [15:0]        wr_data,
   input  logic               in_flash_exec,
   input  logic               stat_rd,
   input  logic [1:0]         rd_addr_lsb,
   input  logic [15:0]        arr_rdata,
   output logic [15:0]        rd_data,
   output logic [NUM_BLK-1:0] blk_permit,
   output logic               set_err
);

   if (NUM_BLK < 1 || NUM_BLK > CODE_BIT) begin : g_bad_nblk
      $error("flash_prot_guard: NUM_BLK must lie in 1..CODE_BIT");
   end
   if (CODE_BIT >= PROT_W) begin : g_bad_code
      $error("flash_prot_guard: CODE_BIT must fit the protection word");
   end

   localparam prot_word_t IMPL_MASK = impl_mask(NUM_BLK, CODE_BIT);

   prot_word_t pend_w;
   prot_word_t act_w;
   logic       blk_tmp;
   logic       code_tmp;
   logic       code_lock;

   fpg_prot_regs #(.IMPL(IMPL_MASK)) u_regs (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_n),
      .set_stb   (set_stb),
      .set_val   (set_val),
      .pend_q    (pend_w),
      .act_q     (act_w),
      .set_err_q (set_err)
   );

   fpg_unlock_ctl #(.UNLOCK_WORD(UNLOCK_WORD), .RELOCK_WORD(RELOCK_WORD)) u_unlock (
      .clk        (clk),
      .por_n      (por_n),
      .rst_n      (rst_n),
      .blk_cmd    (blk_unlock),
      .wr_stb     (wr_stb),
      .wr_data    (wr_data),
      .in_flash   (in_flash_exec),
      .blk_tmp_q  (blk_tmp),
      .code_tmp_q (code_tmp)
   );

   assign code_lock = ~act_w[CODE_BIT] & ~code_tmp;

   fpg_read_sel #(.TRAP_WORD(TRAP_WORD)) u_rsel (
      .stat_rd   (stat_rd),
      .addr_lsb  (rd_addr_lsb),
      .in_flash  (in_flash_exec),
      .code_lock (code_lock),
      .act_word  (act_w),
      .arr_rdata (arr_rdata),
      .rd_data   (rd_data)
   );

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_permit
      assign blk_permit[b] = act_w[b] | blk_tmp;
   end

   AST_PERMIT_HOLD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $past(rst_n && por_n) && !$rose(blk_tmp) |-> $stable(blk_permit)); // R2

endmodule

// File: tb/flash_prot_guard_tb.sv
module flash_prot_guard_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] IMPL = 16'h87FF;
   localparam logic [15:0] TRAP = 16'h009B;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b0;
   logic        set_stb = 1'b0;
   logic [15:0] set_val = '0;
   logic        blk_unlock = 1'b0;
   logic        wr_stb = 1'b0;
   logic [15:0] wr_data = '0;
   logic        in_flash_exec = 1'b0;
   logic        stat_rd = 1'b0;
   logic [1:0]  rd_addr_lsb = 2'b00;
   logic [15:0] arr_rdata = 16'h0000;
   logic [15:0] rd_data;
   logic [10:0] blk_permit;
   logic        set_err;

   int    errors = 0;
   int    checks = 0;
   bit    done = 1'b0;
   string cur_tag = "R1";

   // behavioural reference state
   logic [15:0] m_pend = 16'hFFFF;
   logic [15:0] m_act  = 16'hFFFF;
   bit          m_blk = 1'b0;
   bit          m_code = 1'b0;
   bit          m_err = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_prot_guard u_dut (
      .clk           (clk),
      .por_n         (por_n),
      .rst_n         (rst_n),
      .set_stb       (set_stb),
      .set_val       (set_val),
      .blk_unlock    (blk_unlock),
      .wr_stb        (wr_stb),
      .wr_data       (wr_data),
      .in_flash_exec (in_flash_exec),
      .stat_rd       (stat_rd),
      .rd_addr_lsb   (rd_addr_lsb),
      .arr_rdata     (arr_rdata),
      .rd_data       (rd_data),
      .blk_permit    (blk_permit),
      .set_err       (set_err)
   );

   always @(posedge clk) begin
      if (!por_n) begin
         m_pend <= 16'hFFFF; m_act <= 16'hFFFF;
         m_blk <= 1'b0; m_code <= 1'b0; m_err <= 1'b0;
      end else if (!rst_n) begin
         m_act <= m_pend; m_blk <= 1'b0; m_code <= 1'b0; m_err <= 1'b0;
      end else begin
         m_err <= 1'b0;
         if (set_stb) begin
            if ((~m_pend & set_val & IMPL) != 16'h0) m_err <= 1'b1;
            else m_pend <= set_val | ~IMPL;
         end
         if (blk_unlock) m_blk <= 1'b1;
         if (wr_stb && in_flash_exec) begin
            if (wr_data == 16'hFFFF) m_code <= 1'b1;
            else if (wr_data == 16'hFFFB) m_code <= 1'b0;
         end
      end
   end

   function automatic logic [15:0] model_rd();
      if (stat_rd && rd_addr_lsb == 2'b10) return m_act;
      if (!m_act[15] && !m_code && !in_flash_exec) return TRAP;
      return arr_rdata;
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      if (por_n) begin
         chk({cur_tag, " model permit"}, {5'h0, blk_permit}, {5'h0, m_act[10:0] | {11{m_blk}}});
         chk({cur_tag, " model rd_data"}, rd_data, model_rd());
         chk({cur_tag, " model set_err"}, {15'h0, set_err}, {15'h0, m_err});
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare_model();
   endtask

   task automatic do_set(input logic [15:0] v);
      set_stb = 1'b1; set_val = v; tick(); set_stb = 1'b0;
   endtask

   task automatic do_wr(input logic [15:0] d, input bit fl);
      wr_stb = 1'b1; wr_data = d; in_flash_exec = fl; tick();
      wr_stb = 1'b0; in_flash_exec = 1'b0;
   endtask

   task automatic sys_reset();
      rst_n = 1'b0; tick(); rst_n = 1'b1;
   endtask

   task automatic rd_chk(input string tag, input bit fl, input bit st, input logic [1:0] lsb,
                         input logic [15:0] arr, input logic [15:0] exp);
      in_flash_exec = fl; stat_rd = st; rd_addr_lsb = lsb; arr_rdata = arr;
      #1;
      chk(tag, rd_data, exp);
      compare_model();
   endtask

   initial begin
      repeat (2) tick();
      por_n = 1'b1; tick();
      rst_n = 1'b1; tick();

      cur_tag = "R1";
      chk("R1 permit after power-on", {5'h0, blk_permit}, 16'h07FF);
      rd_chk("R1 status after power-on", 1'b0, 1'b1, 2'b10, 16'h0000, 16'hFFFF);
      rd_chk("R1 no trap after power-on", 1'b0, 1'b0, 2'b00, 16'h3C3C, 16'h3C3C);

      cur_tag = "R3";
      do_set(16'h7FFA);
      chk("R3 accepted set has no error", {15'h0, set_err}, 16'h0000);
      cur_tag = "R5";
      chk("R5 permit unchanged before reset", {5'h0, blk_permit}, 16'h07FF);
      rd_chk("R5 status unchanged before reset", 1'b0, 1'b1, 2'b10, 16'h0000, 16'hFFFF);
      rd_chk("R5 no trap before reset", 1'b0, 1'b0, 2'b00, 16'h1234, 16'h1234);

      cur_tag = "R4";
      do_set(16'hFFFF);
      chk("R4 raising set flags error", {15'h0, set_err}, 16'h0001);
      tick();
      chk("R4 error is one cycle", {15'h0, set_err}, 16'h0000);

      cur_tag = "R5";
      sys_reset(); tick();
      rd_chk("R5 status after reset", 1'b0, 1'b1, 2'b10, 16'h0000, 16'h7FFA);
      cur_tag = "R2";
      chk("R2 blocks 0 and 2 denied", {5'h0, blk_permit}, 16'h07FA);
      cur_tag = "R6";
      rd_chk("R6 outside read trapped", 1'b0, 1'b0, 2'b00, 16'hA5A5, TRAP);
      rd_chk("R6 in-flash read passes", 1'b1, 1'b0, 2'b00, 16'hA5A5, 16'hA5A5);
      cur_tag = "R9";
      rd_chk("R9 status at 4n-2 overrides trap", 1'b0, 1'b1, 2'b10, 16'h5555, 16'h7FFA);
      rd_chk("R9 other address takes array path", 1'b0, 1'b1, 2'b00, 16'h1111, TRAP);
      rd_chk("R9 other address in flash", 1'b1, 1'b1, 2'b01, 16'h1111, 16'h1111);
      stat_rd = 1'b0;

      cur_tag = "R8";
      do_wr(16'hFFFF, 1'b0);
      rd_chk("R8 unlock from outside ignored", 1'b0, 1'b0, 2'b00, 16'h2222, TRAP);
      do_wr(16'hFFFF, 1'b1);
      rd_chk("R8 unlock from flash lifts trap", 1'b0, 1'b0, 2'b00, 16'h2222, 16'h2222);
      do_wr(16'hFFFB, 1'b0);
      rd_chk("R8 relock from outside ignored", 1'b0, 1'b0, 2'b00, 16'h2323, 16'h2323);
      do_wr(16'hFFFB, 1'b1);
      rd_chk("R8 relock from flash restores trap", 1'b0, 1'b0, 2'b00, 16'h2222, TRAP);
      do_wr(16'hFFFF, 1'b1);

      cur_tag = "R7";
      blk_unlock = 1'b1; tick(); blk_unlock = 1'b0;
      chk("R7 block unprotect opens all", {5'h0, blk_permit}, 16'h07FF);
      repeat (3) tick();
      chk("R7 block unprotect persists", {5'h0, blk_permit}, 16'h07FF);

      cur_tag = "R10";
      sys_reset(); tick();
      chk("R10 reset clears block flag", {5'h0, blk_permit}, 16'h07FA);
      rd_chk("R10 reset clears code flag", 1'b0, 1'b0, 2'b00, 16'h4444, TRAP);
      rd_chk("R10 pending kept over reset", 1'b0, 1'b1, 2'b10, 16'h0000, 16'h7FFA);
      stat_rd = 1'b0;

      cur_tag = "R3";
      do_set(16'h0000);
      chk("R3 clear-all accepted", {15'h0, set_err}, 16'h0000);
      sys_reset(); tick();
      rd_chk("R3 unimplemented bits forced to 1", 1'b0, 1'b1, 2'b10, 16'h0000, 16'h7800);
      stat_rd = 1'b0;
      cur_tag = "R2";
      chk("R2 all blocks denied", {5'h0, blk_permit}, 16'h0000);

      cur_tag = "R4";
      do_set(16'h0001);
      chk("R4 raising block bit rejected", {15'h0, set_err}, 16'h0001);
      do_set(16'h8000);
      chk("R4 raising code bit rejected", {15'h0, set_err}, 16'h0001);
      sys_reset(); tick();
      rd_chk("R4 pending unchanged by rejects", 1'b0, 1'b1, 2'b10, 16'h0000, 16'h7800);
      stat_rd = 1'b0;

      cur_tag = "R1";
      por_n = 1'b0; rst_n = 1'b0; tick(); por_n = 1'b1; rst_n = 1'b1; tick();
      rd_chk("R1 power-on restores all ones", 1'b0, 1'b1, 2'b10, 16'h0000, 16'hFFFF);
      chk("R1 power-on permits", {5'h0, blk_permit}, 16'h07FF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule